// File: doc/BRIEF.md
# E3 Transmit Overhead Alarm Controller

This block is the last stage of an E3 transmit framer before line coding. It receives the outgoing frame one byte per cycle. Each byte arrives with a flag that marks it as overhead and a flag that marks it as the maintenance byte. The block returns each byte one clock later, with the alarm and maintenance rules applied. Overhead bytes may come from internal generation or from an external overhead or HDLC insertion path. The block treats all of them the same way.

A small byte-wide register port holds a configuration register and a software alarm register.

The configuration register provides:
- a loss-of-signal command, which zeroes the entire frame, framing bytes included, and overrides every other setting;
- an alarm-indication command, which fills the payload with ones;
- a mode bit, which selects where the far-end receive failure (FERF) and far-end block error (FEBE) bits of the maintenance byte come from.

In software mode those two bits come from the alarm register. In automatic mode they mirror receive-side status flags, which the block samples once per frame at the frame-start strobe.

Top module: `e3_tx_oh_ctl`

## Requirements
- R1: After reset, `out_valid` and `out_byte` are 0, and both registers read 0x00.
- R2: The configuration register is at address 0x30. Its writable bits are:
  - bit 0: automatic maintenance mode;
  - bit 1: LOS command;
  - bit 2: AIS command;
  - bit 4: data-link control.

  Bits 3, 5, 6 and 7 read 0. The alarm register is at 0x31, with software FERF in bit 1 and software FEBE in bit 0; its bits 7:2 read 0. Any other address reads 0x00.
- R3: With LOS and AIS both 0, a byte that is not the maintenance byte is output unchanged.
- R4: With LOS at 1, every output byte is 0x00. This covers overhead (including both framing bytes), the maintenance byte and payload, whatever the AIS and mode bits are.
- R5: With AIS at 1 and LOS at 0, every payload byte is output as 0xFF. Overhead bytes, the maintenance byte included, follow their normal rules.
- R6: In the maintenance byte, FERF is output bit 7 (the first bit sent) and FEBE is output bit 6. Bits 5:0 pass through. With mode at 0, FERF and FEBE take the alarm register values at once.
- R7: With mode at 1, FERF is 1 if any of `rx_los`, `rx_ais` or `rx_lof` was high at the latest frame-start strobe, and 0 otherwise.
- R8: With mode at 1, FEBE equals `rx_bip_err` as sampled at the latest frame-start strobe.
- R9: Receive flags that change between frame-start strobes do not affect the maintenance byte until the next strobe.
- R10: Each result appears one clock after its input byte, and `out_valid` follows `in_valid` with the same one-clock delay.
- R11: The `dl_ctl` output equals bit 4 of the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input frame byte, MSB transmitted first |
| in_is_oh | input | 1 | Input byte is an overhead byte |
| in_is_ma | input | 1 | Input byte is the maintenance byte |
| frame_start | input | 1 | Frame-start strobe; samples the receive flags |
| rx_los | input | 1 | Receive loss of signal |
| rx_ais | input | 1 | Receive alarm indication |
| rx_lof | input | 1 | Receive loss of frame |
| rx_bip_err | input | 1 | Receive BIP-8 error in the previous frame |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output frame byte |
| dl_ctl | output | 1 | Data-link control bit |

## Verification
Register writes take effect at the clock edge after the write. Reads are combinational, and the bench samples them shortly after it sets the address. A data byte driven before an edge produces its result at that edge, so the bench checks `out_byte` and `out_valid` at the following falling edge.

Receive flags are captured at the edge of a byte that carries `frame_start`. The first maintenance byte sent after that byte shows them. The bench therefore changes the flags only between strobes and then checks that the maintenance byte has not moved.

// File: rtl/e3_tx_oh_ctl.sv
module e3_tx_oh_ctl #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] CFG_ADDR = 8'h30,
  parameter logic [AW-1:0] ALM_ADDR = 8'h31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          in_is_oh,
  input  logic          in_is_ma,
  input  logic          frame_start,
  input  logic          rx_los,
  input  logic          rx_ais,
  input  logic          rx_lof,
  input  logic          rx_bip_err,
  output logic          out_valid,
  output logic [DW-1:0] out_byte,
  output logic          dl_ctl
);

  logic cfg_auto, cfg_los, cfg_ais, cfg_dl;
  logic sw_ferf, sw_febe;
  logic smp_ferf, smp_febe;
  logic ferf_v, febe_v, is_pay;
  logic [DW-1:0] nxt_byte;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[DW-1:5], reg_wdata[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_auto <= 1'b0;
      cfg_los  <= 1'b0;
      cfg_ais  <= 1'b0;
      cfg_dl   <= 1'b0;
      sw_ferf  <= 1'b0;
      sw_febe  <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == CFG_ADDR) begin
        cfg_auto <= reg_wdata[0];
        cfg_los  <= reg_wdata[1];
        cfg_ais  <= reg_wdata[2];
        cfg_dl   <= reg_wdata[4];
      end else if (reg_addr == ALM_ADDR) begin
        sw_febe <= reg_wdata[0];
        sw_ferf <= reg_wdata[1];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CFG_ADDR) begin
      reg_rdata[0] = cfg_auto;
      reg_rdata[1] = cfg_los;
      reg_rdata[2] = cfg_ais;
      reg_rdata[4] = cfg_dl;
    end else if (reg_addr == ALM_ADDR) begin
      reg_rdata[0] = sw_febe;
      reg_rdata[1] = sw_ferf;
    end
  end

  assign dl_ctl = cfg_dl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_ferf <= 1'b0;
      smp_febe <= 1'b0;
    end else if (frame_start) begin
      smp_ferf <= rx_los | rx_ais | rx_lof;
      smp_febe <= rx_bip_err;
    end
  end

  assign ferf_v = cfg_auto ? smp_ferf : sw_ferf;
  assign febe_v = cfg_auto ? smp_febe : sw_febe;
  assign is_pay = !in_is_oh && !in_is_ma;

  always_comb begin
    nxt_byte = in_byte;
    if (cfg_los)
      nxt_byte = '0;
    else if (in_is_ma)
      nxt_byte = {ferf_v, febe_v, in_byte[DW-3:0]};
    else if (cfg_ais && is_pay)
      nxt_byte = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      out_byte  <= nxt_byte;
    end
  end

  a_r4_los_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_los |=> (out_byte == '0));

  a_r5_ais_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_los && cfg_ais && is_pay) |=> (out_byte == '1));

  a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_los && !cfg_ais && !in_is_ma) |=> (out_byte == $past(in_byte)));

  a_r6_ma_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_los && in_is_ma) |=> (out_byte[DW-3:0] == $past(in_byte[DW-3:0])));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(smp_ferf) && $stable(smp_febe)));

  a_r10_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_cfg_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CFG_ADDR) |-> (reg_rdata[7:5] == 3'b0 && reg_rdata[3] == 1'b0));

endmodule

// File: tb/e3_tx_oh_ctl_test.sv
module e3_tx_oh_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic in_valid = 1'b0, in_is_oh = 1'b0, in_is_ma = 1'b0, frame_start = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic rx_los = 1'b0, rx_ais = 1'b0, rx_lof = 1'b0, rx_bip_err = 1'b0;
  logic out_valid, dl_ctl;
  logic [7:0] out_byte;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  e3_tx_oh_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_byte(in_byte), .in_is_oh(in_is_oh), .in_is_ma(in_is_ma),
    .frame_start(frame_start), .rx_los(rx_los), .rx_ais(rx_ais),
    .rx_lof(rx_lof), .rx_bip_err(rx_bip_err), .out_valid(out_valid),
    .out_byte(out_byte), .dl_ctl(dl_ctl)
  );

  // cfg[41:34] alm[33:26] oh[25] ma[24] in[23:16] exp[15:8] tag[7:0]
  localparam logic [41:0] VEC [14] = '{
    {8'h00, 8'h00, 1'b1, 1'b0, 8'hA5, 8'hA5, 8'd3},
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h3C, 8'h3C, 8'd3},
    {8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 8'h3F, 8'd6},
    {8'h00, 8'h02, 1'b1, 1'b1, 8'h00, 8'h80, 8'd6},
    {8'h00, 8'h01, 1'b1, 1'b1, 8'h15, 8'h55, 8'd6},
    {8'h00, 8'h03, 1'b1, 1'b1, 8'h2A, 8'hEA, 8'd6},
    {8'h04, 8'h00, 1'b0, 1'b0, 8'h12, 8'hFF, 8'd5},
    {8'h04, 8'h00, 1'b1, 1'b0, 8'hF6, 8'hF6, 8'd5},
    {8'h04, 8'h03, 1'b1, 1'b1, 8'h01, 8'hC1, 8'd5},
    {8'h02, 8'h00, 1'b1, 1'b0, 8'hF6, 8'h00, 8'd4},
    {8'h02, 8'h00, 1'b1, 1'b0, 8'h28, 8'h00, 8'd4},
    {8'h06, 8'h03, 1'b0, 1'b0, 8'h5A, 8'h00, 8'd4},
    {8'h07, 8'h03, 1'b1, 1'b1, 8'hFF, 8'h00, 8'd4},
    {8'h12, 8'h00, 1'b0, 1'b0, 8'h77, 8'h00, 8'd4}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic oh, input logic ma, input logic fs,
                      input logic [7:0] b, output logic [7:0] o, output logic v);
    @(negedge clk);
    in_valid = 1'b1; in_is_oh = oh; in_is_ma = ma; frame_start = fs; in_byte = b;
    @(negedge clk);
    o = out_byte; v = out_valid;
    in_valid = 1'b0; in_is_oh = 1'b0; in_is_ma = 1'b0; frame_start = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, o;
    logic v;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {7'b0, out_valid}, 8'h00);
    chk("R1 out_byte", out_byte, 8'h00);
    rst_n = 1'b1;
    rd(8'h30, r); chk("R1 cfg", r, 8'h00);
    rd(8'h31, r); chk("R1 alm", r, 8'h00);

    foreach (VEC[i]) begin
      wr(8'h30, VEC[i][41:34]);
      wr(8'h31, VEC[i][33:26]);
      send(VEC[i][25], VEC[i][24], 1'b0, VEC[i][23:16], o, v);
      chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), o, VEC[i][15:8]);
      chk("R10 valid", {7'b0, v}, 8'h01);
    end
    @(negedge clk);
    chk("R10 valid low", {7'b0, out_valid}, 8'h00);

    wr(8'h30, 8'hFF); rd(8'h30, r); chk("R2 cfg mask", r, 8'h17);
    chk("R11 dl_ctl high", {7'b0, dl_ctl}, 8'h01);
    wr(8'h31, 8'hFF); rd(8'h31, r); chk("R2 alm mask", r, 8'h03);
    rd(8'h32, r); chk("R2 unmapped", r, 8'h00);
    wr(8'h30, 8'h00);
    chk("R11 dl_ctl low", {7'b0, dl_ctl}, 8'h00);

    wr(8'h31, 8'h00);
    wr(8'h30, 8'h01);
    rx_los = 1'b1;
    send(1'b1, 1'b0, 1'b1, 8'hF6, o, v);
    rx_los = 1'b0;
    send(1'b1, 1'b1, 1'b0, 8'h00, o, v);
    chk("R7 ferf from los", o, 8'h80);
    rx_bip_err = 1'b1;
    send(1'b1, 1'b0, 1'b1, 8'hF6, o, v);
    rx_bip_err = 1'b0;
    send(1'b1, 1'b1, 1'b0, 8'h05, o, v);
    chk("R8 febe from bip", o, 8'h45);
    rx_ais = 1'b1;
    send(1'b1, 1'b1, 1'b0, 8'h00, o, v);
    chk("R9 held between strobes", o, 8'h40);
    send(1'b1, 1'b0, 1'b1, 8'hF6, o, v);
    rx_ais = 1'b0;
    send(1'b1, 1'b1, 1'b0, 8'h00, o, v);
    chk("R7 ferf from ais", o, 8'h80);
    rx_lof = 1'b1;
    send(1'b1, 1'b0, 1'b1, 8'hF6, o, v);
    rx_lof = 1'b0;
    wr(8'h31, 8'h01);
    send(1'b1, 1'b1, 1'b0, 8'h00, o, v);
    chk("R7 ferf from lof ignores sw", o, 8'h80);
    send(1'b1, 1'b0, 1'b1, 8'hF6, o, v);
    send(1'b1, 1'b1, 1'b0, 8'h00, o, v);
    chk("R8 clear after clean frame", o, 8'h00);
    wr(8'h30, 8'h00);
    send(1'b1, 1'b1, 1'b0, 8'h00, o, v);
    chk("R6 back to sw values", o, 8'h40);
    wr(8'h30, 8'h03);
    rx_los = 1'b1;
    send(1'b1, 1'b0, 1'b1, 8'hF6, o, v);
    chk("R4 los over auto fa", o, 8'h00);
    send(1'b1, 1'b1, 1'b0, 8'h3F, o, v);
    chk("R4 los over auto ma", o, 8'h00);
    rx_los = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule